// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block joins a fast coprocessor and a slow host processor with a one-byte mailbox in each direction. Each side runs on its own clock, and neither side ever waits for the other. The coprocessor reaches the mailbox through a small group of I/O ports. One port carries data in both directions and another reports status. The host sees the same mailbox as four memory-mapped locations. These sit in a slot window whose base moves with the slot number the card is plugged into.

Each direction has a holding register and a full flag. A write fills the register and a read of the data empties it. A byte waits in its register for as long as it takes the far side to collect it. The flag changes cross between the clocks as toggle signals, each through a multi-flop synchronizer. The host gets an interrupt when a byte from the coprocessor arrives. It also gets one when the coprocessor takes the byte the host left for it. Each of these two causes has its own pending bit and its own enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: A coprocessor write to port 0 places the byte in the outbound register. The host then reads it at window offset 0 and reads the same byte. The host read empties the register.
- R2: A host write to window offset 0 places the byte in the inbound register. The coprocessor then reads it at port 0 and reads the same byte. The coprocessor read empties the register.
- R3: Reading coprocessor port 1 returns bit 0 = inbound byte available, bit 1 = outbound register empty, and bit 2 = coprocessor overrun. All other bits read 0. Ports 2 and 3 read 0.
- R4: Reading host offset 1 returns bit 0 = outbound byte available to the host, bit 1 = inbound register empty, bit 2 = host overrun, bit 4 = arrival pending and bit 5 = taken pending. All other bits read 0.
- R5: An accepted coprocessor write sets the arrival pending bit (bit 4).
- R6: A coprocessor read that empties the inbound register sets the taken pending bit (bit 5).
- R7: A host read of offset 1 clears both pending bits. An event that lands in the same host cycle as that read survives it, so the event shows in a later status read.
- R8: Host offset 2 holds the interrupt enables: bit 0 for arrival and bit 1 for taken. It reads back with the same layout. The interrupt output is high exactly when some pending bit has its enable set.
- R9: A write while that side's outgoing register is still full is ignored: the held byte is kept and the side's sticky overrun bit is set.
- R10: A coprocessor write to port 1 clears the coprocessor overrun bit. A host write to offset 3 clears the host overrun bit.
- R11: The host window base is 0xC080 + 16 × slot, and only offsets 0 to 3 respond. Other addresses read 0 and writes to them are ignored.
- R12: A waiting byte stays available with no time limit. Reading a data location while it is empty returns the last byte and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp_clk | input | 1 | Coprocessor clock |
| cp_rst_n | input | 1 | Coprocessor-domain asynchronous reset, active low |
| cp_port | input | CP_ADDR_W | Coprocessor I/O port number |
| cp_rd | input | 1 | Coprocessor read strobe, one cycle per access |
| cp_wr | input | 1 | Coprocessor write strobe, one cycle per access |
| cp_wdata | input | DATA_W | Coprocessor write data |
| cp_rdata | output | DATA_W | Coprocessor read data, combinational from the port number |
| hs_clk | input | 1 | Host clock |
| hs_rst_n | input | 1 | Host-domain asynchronous reset, active low |
| hs_slot | input | SLOT_W | Slot number that places the host window |
| hs_addr | input | ADDR_W | Host address |
| hs_rd | input | 1 | Host read strobe, one cycle per access |
| hs_wr | input | 1 | Host write strobe, one cycle per access |
| hs_wdata | input | DATA_W | Host write data |
| hs_rdata | output | DATA_W | Host read data, 0 outside the window |
| hs_irq | output | 1 | Host interrupt request, level |

## Verification
Two things can fall in the same host cycle. One is a status read that clears the pending bits. The other is a pending event that has just come out of a synchronizer. The bench provokes this by issuing a status read on eight host cycles in a row, straight after a coprocessor write or read. The crossing then lands inside that run of reads. The outcome is right only if exactly one read in the run shows the pending bit: zero means the clear beat the event, and two means the event pulse lasted too long.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int NUM_REGS   = 4;
   localparam int NUM_CAUSES = 2;

   typedef enum logic [1:0] {
      HOFF_DATA  = 2'd0,
      HOFF_STAT  = 2'd1,
      HOFF_IEN   = 2'd2,
      HOFF_OVCLR = 2'd3
   } host_off_e;

   localparam int CP_DATA_PORT = 0;
   localparam int CP_STAT_PORT = 1;

   localparam int ST_AVAIL     = 0;
   localparam int ST_ROOM      = 1;
   localparam int ST_OVR       = 2;
   localparam int ST_PEND_ARR  = 4;
   localparam int ST_PEND_TAKE = 5;
   localparam int ST_MIN_W     = 6;

   localparam int CAUSE_ARRIVE = 0;
   localparam int CAUSE_TAKEN  = 1;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= 1'b0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= 1'b0;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              w_clk,
   input  logic              w_rst_n,
   input  logic              w_push,
   input  logic [DATA_W-1:0] w_data,
   output logic              w_full,
   output logic              w_reject,
   output logic              w_taken,
   input  logic              r_clk,
   input  logic              r_rst_n,
   input  logic              r_pop,
   output logic              r_avail,
   output logic [DATA_W-1:0] r_data,
   output logic              r_arrived
);

   logic              w_tog;
   logic              r_tog;
   logic              r_tog_at_w;
   logic              r_tog_at_w_d;
   logic              w_tog_at_r;
   logic              w_tog_at_r_d;
   logic              w_accept;
   logic [DATA_W-1:0] hold_q;

   mbx_sync #(.STAGES(SYNC_STAGES)) u_r2w (
      .clk  (w_clk),
      .rst_n(w_rst_n),
      .d    (r_tog),
      .q    (r_tog_at_w)
   );

   mbx_sync #(.STAGES(SYNC_STAGES)) u_w2r (
      .clk  (r_clk),
      .rst_n(r_rst_n),
      .d    (w_tog),
      .q    (w_tog_at_r)
   );

   // writer domain
   assign w_full   = w_tog ^ r_tog_at_w;
   assign w_accept = w_push & ~w_full;
   assign w_reject = w_push & w_full;
   assign w_taken  = r_tog_at_w ^ r_tog_at_w_d;

   always_ff @(posedge w_clk or negedge w_rst_n) begin
      if (!w_rst_n) begin
         w_tog        <= 1'b0;
         hold_q       <= '0;
         r_tog_at_w_d <= 1'b0;
      end else begin
         r_tog_at_w_d <= r_tog_at_w;
         if (w_accept) begin
            w_tog  <= ~w_tog;
            hold_q <= w_data;
         end
      end
   end

   // reader domain
   assign r_avail   = w_tog_at_r ^ r_tog;
   assign r_data    = hold_q;
   assign r_arrived = w_tog_at_r ^ w_tog_at_r_d;

   always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n) begin
         r_tog        <= 1'b0;
         w_tog_at_r_d <= 1'b0;
      end else begin
         w_tog_at_r_d <= w_tog_at_r;
         if (r_pop && r_avail) r_tog <= ~r_tog;
      end
   end

   p_full_rises_on_push_r1 : assert property (@(posedge w_clk) disable iff (!w_rst_n)
      $rose(w_full) |-> $past(w_push));

   p_reject_keeps_byte_r9 : assert property (@(posedge w_clk) disable iff (!w_rst_n)
      (w_push && w_full) |=> $stable(r_data));

   p_avail_falls_on_pop_r12 : assert property (@(posedge r_clk) disable iff (!r_rst_n)
      $fell(r_avail) |-> $past(r_pop));

endmodule

// File: rtl/mbx_cp_if.sv
module mbx_cp_if
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CP_ADDR_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CP_ADDR_W-1:0] port,
   input  logic                 rd,
   input  logic                 wr,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 h2c_avail,
   input  logic [DATA_W-1:0]    h2c_data,
   output logic                 h2c_pop,
   input  logic                 c2h_full,
   input  logic                 c2h_reject,
   output logic                 c2h_push
);

   logic sel_data;
   logic sel_stat;
   logic ovr_q;

   assign sel_data = (port == CP_ADDR_W'(CP_DATA_PORT));
   assign sel_stat = (port == CP_ADDR_W'(CP_STAT_PORT));
   assign h2c_pop  = rd & sel_data;
   assign c2h_push = wr & sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ovr_q <= 1'b0;
      else if (c2h_reject)      ovr_q <= 1'b1;
      else if (wr && sel_stat)  ovr_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (sel_data) begin
         rdata = h2c_data;
      end else if (sel_stat) begin
         rdata[ST_AVAIL] = h2c_avail;
         rdata[ST_ROOM]  = ~c2h_full;
         rdata[ST_OVR]   = ovr_q;
      end
   end

   p_cp_ovr_cause_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(c2h_full && wr));

   p_cp_ovr_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_q) |-> $past(wr && sel_stat));

endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
   import mbx_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 16,
   parameter int                SLOT_W      = 3,
   parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'hC080,
   parameter int                SLOT_STRIDE = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SLOT_W-1:0]     slot,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  rd,
   input  logic                  wr,
   input  logic [NUM_CAUSES-1:0] ien_wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  irq,
   input  logic                  c2h_avail,
   input  logic [DATA_W-1:0]     c2h_data,
   input  logic                  c2h_arrived,
   output logic                  c2h_pop,
   input  logic                  h2c_full,
   input  logic                  h2c_reject,
   input  logic                  h2c_taken,
   output logic                  h2c_push
);

   localparam int OFF_W = $clog2(NUM_REGS);
   localparam int HI_W  = ADDR_W - OFF_W;
   localparam logic [HI_W-1:0] BASE_HI   = HI_W'(WINDOW_BASE >> OFF_W);
   localparam logic [HI_W-1:0] STRIDE_HI = HI_W'(SLOT_STRIDE / NUM_REGS);

   logic [HI_W-1:0]       win_hi;
   logic                  hit;
   host_off_e             off;
   logic                  stat_rd;
   logic                  ovr_clr;
   logic                  ovr_q;
   logic [NUM_CAUSES-1:0] ien_q;
   logic [NUM_CAUSES-1:0] pend_q;
   logic [NUM_CAUSES-1:0] evt;

   assign win_hi  = BASE_HI + STRIDE_HI * HI_W'(slot);
   assign hit     = (addr[ADDR_W-1:OFF_W] == win_hi);
   assign off     = host_off_e'(addr[OFF_W-1:0]);
   assign stat_rd = hit & rd & (off == HOFF_STAT);
   assign ovr_clr = hit & wr & (off == HOFF_OVCLR);
   assign c2h_pop  = hit & rd & (off == HOFF_DATA);
   assign h2c_push = hit & wr & (off == HOFF_DATA);

   assign evt[CAUSE_ARRIVE] = c2h_arrived;
   assign evt[CAUSE_TAKEN]  = h2c_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         ovr_q  <= 1'b0;
         pend_q <= '0;
      end else begin
         if (hit && wr && (off == HOFF_IEN)) ien_q <= ien_wdata;
         if (h2c_reject)   ovr_q <= 1'b1;
         else if (ovr_clr) ovr_q <= 1'b0;
         for (int i = 0; i < NUM_CAUSES; i++) begin
            if (evt[i])       pend_q[i] <= 1'b1;
            else if (stat_rd) pend_q[i] <= 1'b0;
         end
      end
   end

   assign irq = |(pend_q & ien_q);

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (off)
            HOFF_DATA: rdata = c2h_data;
            HOFF_STAT: begin
               rdata[ST_AVAIL]     = c2h_avail;
               rdata[ST_ROOM]      = ~h2c_full;
               rdata[ST_OVR]       = ovr_q;
               rdata[ST_PEND_ARR]  = pend_q[CAUSE_ARRIVE];
               rdata[ST_PEND_TAKE] = pend_q[CAUSE_TAKEN];
            end
            HOFF_IEN:  rdata = DATA_W'(ien_q);
            default:   rdata = '0;
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause_chk
      p_pend_clear_needs_read_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_q[c]) |-> $past(rd && (addr[OFF_W-1:0] == OFF_W'(HOFF_STAT))));
      p_event_wins_over_read_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         evt[c] |=> pend_q[c]);
   end

   p_irq_follows_enable_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   p_host_ovr_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_q) |-> $past(wr && hit));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                CP_ADDR_W   = 2,
   parameter int                ADDR_W      = 16,
   parameter int                SLOT_W      = 3,
   parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'hC080,
   parameter int                SLOT_STRIDE = 16,
   parameter int                SYNC_STAGES = 2
) (
   input  logic                 cp_clk,
   input  logic                 cp_rst_n,
   input  logic [CP_ADDR_W-1:0] cp_port,
   input  logic                 cp_rd,
   input  logic                 cp_wr,
   input  logic [DATA_W-1:0]    cp_wdata,
   output logic [DATA_W-1:0]    cp_rdata,
   input  logic                 hs_clk,
   input  logic                 hs_rst_n,
   input  logic [SLOT_W-1:0]    hs_slot,
   input  logic [ADDR_W-1:0]    hs_addr,
   input  logic                 hs_rd,
   input  logic                 hs_wr,
   input  logic [DATA_W-1:0]    hs_wdata,
   output logic [DATA_W-1:0]    hs_rdata,
   output logic                 hs_irq
);

   initial begin
      if (DATA_W < ST_MIN_W)           $fatal(1, "DATA_W too narrow for status layout");
      if (SYNC_STAGES < 2)             $fatal(1, "SYNC_STAGES must be at least 2");
      if (CP_ADDR_W < 1)               $fatal(1, "CP_ADDR_W must be at least 1");
      if (SLOT_STRIDE < NUM_REGS)      $fatal(1, "SLOT_STRIDE smaller than register count");
      if (SLOT_STRIDE % NUM_REGS != 0) $fatal(1, "SLOT_STRIDE not a multiple of register count");
      if (int'(WINDOW_BASE) % NUM_REGS != 0) $fatal(1, "WINDOW_BASE misaligned");
   end

   logic              c2h_push, c2h_full, c2h_reject, c2h_avail, c2h_arrived, c2h_pop;
   logic              h2c_push, h2c_full, h2c_reject, h2c_avail, h2c_taken, h2c_pop;
   logic [DATA_W-1:0] c2h_data, h2c_data;
   logic              c2h_taken_unused, h2c_arrived_unused;

   mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_c2h (
      .w_clk    (cp_clk),
      .w_rst_n  (cp_rst_n),
      .w_push   (c2h_push),
      .w_data   (cp_wdata),
      .w_full   (c2h_full),
      .w_reject (c2h_reject),
      .w_taken  (c2h_taken_unused),
      .r_clk    (hs_clk),
      .r_rst_n  (hs_rst_n),
      .r_pop    (c2h_pop),
      .r_avail  (c2h_avail),
      .r_data   (c2h_data),
      .r_arrived(c2h_arrived)
   );

   mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_h2c (
      .w_clk    (hs_clk),
      .w_rst_n  (hs_rst_n),
      .w_push   (h2c_push),
      .w_data   (hs_wdata),
      .w_full   (h2c_full),
      .w_reject (h2c_reject),
      .w_taken  (h2c_taken),
      .r_clk    (cp_clk),
      .r_rst_n  (cp_rst_n),
      .r_pop    (h2c_pop),
      .r_avail  (h2c_avail),
      .r_data   (h2c_data),
      .r_arrived(h2c_arrived_unused)
   );

   mbx_cp_if #(.DATA_W(DATA_W), .CP_ADDR_W(CP_ADDR_W)) u_cp (
      .clk       (cp_clk),
      .rst_n     (cp_rst_n),
      .port      (cp_port),
      .rd        (cp_rd),
      .wr        (cp_wr),
      .rdata     (cp_rdata),
      .h2c_avail (h2c_avail),
      .h2c_data  (h2c_data),
      .h2c_pop   (h2c_pop),
      .c2h_full  (c2h_full),
      .c2h_reject(c2h_reject),
      .c2h_push  (c2h_push)
   );

   mbx_host_if #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .SLOT_W     (SLOT_W),
      .WINDOW_BASE(WINDOW_BASE),
      .SLOT_STRIDE(SLOT_STRIDE)
   ) u_hs (
      .clk        (hs_clk),
      .rst_n      (hs_rst_n),
      .slot       (hs_slot),
      .addr       (hs_addr),
      .rd         (hs_rd),
      .wr         (hs_wr),
      .ien_wdata  (hs_wdata[NUM_CAUSES-1:0]),
      .rdata      (hs_rdata),
      .irq        (hs_irq),
      .c2h_avail  (c2h_avail),
      .c2h_data   (c2h_data),
      .c2h_arrived(c2h_arrived),
      .c2h_pop    (c2h_pop),
      .h2c_full   (h2c_full),
      .h2c_reject (h2c_reject),
      .h2c_taken  (h2c_taken),
      .h2c_push   (h2c_push)
   );

endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;

   localparam int CP_PERIOD = 10;
   localparam int HS_PERIOD = 72;

   logic       cp_clk = 1'b0, hs_clk = 1'b0;
   logic       cp_rst_n = 1'b0, hs_rst_n = 1'b0;
   logic [1:0] cp_port = '0;
   logic       cp_rd = 1'b0, cp_wr = 1'b0;
   logic [7:0] cp_wdata = '0, cp_rdata;
   logic [2:0] hs_slot = '0;
   logic [15:0] hs_addr = '0;
   logic       hs_rd = 1'b0, hs_wr = 1'b0;
   logic [7:0] hs_wdata = '0, hs_rdata;
   logic       hs_irq;

   ipc_mailbox u_ipc_mailbox (
      .cp_clk(cp_clk), .cp_rst_n(cp_rst_n), .cp_port(cp_port), .cp_rd(cp_rd),
      .cp_wr(cp_wr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
      .hs_clk(hs_clk), .hs_rst_n(hs_rst_n), .hs_slot(hs_slot), .hs_addr(hs_addr),
      .hs_rd(hs_rd), .hs_wr(hs_wr), .hs_wdata(hs_wdata), .hs_rdata(hs_rdata),
      .hs_irq(hs_irq)
   );

   always #(CP_PERIOD/2) cp_clk = ~cp_clk;
   always #(HS_PERIOD/2) hs_clk = ~hs_clk;

   // behavioural reference state
   bit       m_c2h_full, m_h2c_full, m_cp_ovr, m_hs_ovr;
   bit [7:0] m_c2h_data, m_h2c_data;
   bit [1:0] m_pend, m_ien;
   int       m_slot;
   bit       settled = 1'b0;
   bit       done = 1'b0;
   int       compared = 0, mismatched = 0;

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] base_of(input int s);
      return 16'hC080 + 16'(16 * s);
   endfunction

   function automatic bit in_window(input logic [15:0] a);
      logic [15:0] b;
      b = base_of(m_slot);
      return a[15:2] == b[15:2];
   endfunction

   function automatic logic [7:0] cp_status();
      return {5'b0, m_cp_ovr, ~m_c2h_full, m_h2c_full};
   endfunction

   function automatic logic [7:0] hs_status();
      return {2'b0, m_pend[1], m_pend[0], 1'b0, m_hs_ovr, ~m_h2c_full, m_c2h_full};
   endfunction

   task automatic settle();
      repeat (6) @(negedge hs_clk);
      settled = 1'b1;
   endtask

   task automatic cp_op(input bit wr, input logic [1:0] port, input logic [7:0] d,
                        input string tag, input bit do_settle);
      logic [7:0] exp;
      settled = 1'b0;
      @(negedge cp_clk);
      cp_port = port;
      if (wr) begin
         cp_wr = 1'b1;
         cp_wdata = d;
         if (port == 2'd0) begin
            if (m_c2h_full) m_cp_ovr = 1'b1;
            else begin m_c2h_full = 1'b1; m_c2h_data = d; m_pend[0] = 1'b1; end
         end else if (port == 2'd1) m_cp_ovr = 1'b0;
      end else begin
         cp_rd = 1'b1;
         #1;
         exp = (port == 2'd0) ? m_h2c_data : (port == 2'd1) ? cp_status() : 8'h00;
         check8(tag, cp_rdata, exp);
         if (port == 2'd0 && m_h2c_full) begin m_h2c_full = 1'b0; m_pend[1] = 1'b1; end
      end
      @(negedge cp_clk);
      cp_wr = 1'b0;
      cp_rd = 1'b0;
      if (do_settle) settle();
   endtask

   task automatic hs_op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input string tag);
      logic [7:0] exp;
      bit hit;
      settled = 1'b0;
      hit = in_window(a);
      @(negedge hs_clk);
      hs_addr = a;
      if (wr) begin
         hs_wr = 1'b1;
         hs_wdata = d;
         if (hit) begin
            case (a[1:0])
               2'd0: if (m_h2c_full) m_hs_ovr = 1'b1;
                     else begin m_h2c_full = 1'b1; m_h2c_data = d; end
               2'd2: m_ien = d[1:0];
               2'd3: m_hs_ovr = 1'b0;
               default: ;
            endcase
         end
      end else begin
         hs_rd = 1'b1;
         #1;
         exp = 8'h00;
         if (hit) begin
            case (a[1:0])
               2'd0: exp = m_c2h_data;
               2'd1: exp = hs_status();
               2'd2: exp = {6'b0, m_ien};
               default: exp = 8'h00;
            endcase
         end
         check8(tag, hs_rdata, exp);
         if (hit && a[1:0] == 2'd0) m_c2h_full = 1'b0;
         if (hit && a[1:0] == 2'd1) m_pend = 2'b00;
      end
      @(negedge hs_clk);
      hs_wr = 1'b0;
      hs_rd = 1'b0;
      settle();
   endtask

   // back-to-back status reads; counts reads showing each pending bit
   task automatic hs_burst(output int ones_arr, output int ones_take);
      ones_arr = 0;
      ones_take = 0;
      settled = 1'b0;
      @(negedge hs_clk);
      hs_addr = base_of(m_slot) + 16'd1;
      hs_rd = 1'b1;
      for (int k = 0; k < 8; k++) begin
         #1;
         if (hs_rdata[4]) ones_arr++;
         if (hs_rdata[5]) ones_take++;
         @(negedge hs_clk);
      end
      hs_rd = 1'b0;
      m_pend = 2'b00;
      settle();
   endtask

   // interrupt level compared with the model on every settled host clock (R8)
   always @(negedge hs_clk) begin
      if (settled && !done) check8("R8 irq level", {7'b0, hs_irq}, {7'b0, |(m_pend & m_ien)});
   end

   initial begin
      #(HS_PERIOD * 60000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired before the run completed");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int a0, a1;
      logic [15:0] b;
      m_slot = 3;
      hs_slot = 3'd3;
      repeat (5) @(negedge hs_clk);
      cp_rst_n = 1'b1;
      hs_rst_n = 1'b1;
      settle();
      b = base_of(3);

      // reset state
      check8("R8 reset irq", {7'b0, hs_irq}, 8'h00);
      cp_op(1'b0, 2'd1, 8'h00, "R3 reset cp status", 1'b1);
      hs_op(1'b0, b + 16'd1, 8'h00, "R4 reset host status");
      cp_op(1'b0, 2'd2, 8'h00, "R3 unused port reads 0", 1'b1);

      // slot decode
      hs_op(1'b1, base_of(5), 8'h77, "R11 wrong slot write");
      cp_op(1'b0, 2'd1, 8'h00, "R11 wrong slot write ignored", 1'b1);
      hs_op(1'b0, b + 16'd4, 8'h00, "R11 offset 4 reads 0");

      // coprocessor to host
      cp_op(1'b1, 2'd0, 8'h5A, "R1 write", 1'b1);
      cp_op(1'b0, 2'd1, 8'h00, "R3 outbound full", 1'b1);
      hs_op(1'b0, b + 16'd1, 8'h00, "R5 arrival pending in status");
      hs_op(1'b0, b + 16'd0, 8'h00, "R1 host reads byte");
      hs_op(1'b0, b + 16'd1, 8'h00, "R4 status after read");
      cp_op(1'b0, 2'd1, 8'h00, "R1 outbound empty again", 1'b1);

      // enables and interrupt
      hs_op(1'b1, b + 16'd2, 8'hFD, "R8 enable write");
      hs_op(1'b0, b + 16'd2, 8'h00, "R8 enable readback");
      cp_op(1'b1, 2'd0, 8'h33, "R5 write", 1'b1);
      check8("R5 irq raised", {7'b0, hs_irq}, 8'h01);
      hs_op(1'b0, b + 16'd1, 8'h00, "R7 status read clears");
      check8("R7 irq cleared", {7'b0, hs_irq}, 8'h00);
      hs_op(1'b0, b + 16'd0, 8'h00, "R1 second byte");

      // host to coprocessor
      hs_op(1'b1, b + 16'd2, 8'h02, "R8 enable taken only");
      hs_op(1'b1, b + 16'd0, 8'hC3, "R2 host write");
      cp_op(1'b0, 2'd1, 8'h00, "R3 inbound available", 1'b1);
      check8("R8 no irq before take", {7'b0, hs_irq}, 8'h00);
      cp_op(1'b0, 2'd0, 8'h00, "R2 coprocessor reads byte", 1'b1);
      check8("R6 irq on take", {7'b0, hs_irq}, 8'h01);
      hs_op(1'b0, b + 16'd1, 8'h00, "R6 taken pending in status");

      // overrun
      cp_op(1'b1, 2'd0, 8'h11, "R9 first write", 1'b1);
      cp_op(1'b1, 2'd0, 8'h22, "R9 write while full", 1'b1);
      cp_op(1'b0, 2'd1, 8'h00, "R9 cp overrun set", 1'b1);
      hs_op(1'b0, b + 16'd0, 8'h00, "R9 first byte kept");
      hs_op(1'b1, b + 16'd0, 8'hA1, "R9 host first write");
      hs_op(1'b1, b + 16'd0, 8'hB2, "R9 host write while full");
      hs_op(1'b0, b + 16'd1, 8'h00, "R9 host overrun set");
      cp_op(1'b0, 2'd0, 8'h00, "R9 host byte kept", 1'b1);
      cp_op(1'b1, 2'd1, 8'h00, "R10 cp overrun clear", 1'b1);
      cp_op(1'b0, 2'd1, 8'h00, "R10 cp overrun cleared", 1'b1);
      hs_op(1'b1, b + 16'd3, 8'h00, "R10 host overrun clear");
      hs_op(1'b0, b + 16'd1, 8'h00, "R10 host overrun cleared");

      // no deadline, empty reads
      cp_op(1'b1, 2'd0, 8'h6E, "R12 write", 1'b1);
      repeat (2000) @(negedge hs_clk);
      hs_op(1'b0, b + 16'd1, 8'h00, "R12 still available");
      hs_op(1'b0, b + 16'd0, 8'h00, "R12 byte after long wait");
      hs_op(1'b0, b + 16'd0, 8'h00, "R12 empty read returns last byte");
      hs_op(1'b0, b + 16'd1, 8'h00, "R12 empty read changes no flag");
      cp_op(1'b0, 2'd0, 8'h00, "R12 cp empty read", 1'b1);
      cp_op(1'b0, 2'd1, 8'h00, "R12 cp flags unchanged", 1'b1);

      // event coinciding with status reads
      hs_op(1'b1, b + 16'd2, 8'h00, "R8 enables off");
      cp_op(1'b1, 2'd0, 8'h4B, "R7 write before burst", 1'b0);
      hs_burst(a0, a1);
      check8("R7 arrival seen once in burst", 8'(a0), 8'd1);
      hs_op(1'b0, b + 16'd0, 8'h00, "R7 burst byte");
      hs_op(1'b1, b + 16'd0, 8'h9C, "R7 host write before burst");
      cp_op(1'b0, 2'd0, 8'h00, "R7 take before burst", 1'b0);
      hs_burst(a0, a1);
      check8("R7 taken seen once in burst", 8'(a1), 8'd1);

      // move the window
      m_slot = 0;
      hs_slot = 3'd0;
      b = base_of(0);
      hs_op(1'b1, b + 16'd2, 8'h03, "R11 slot 0 enable write");
      hs_op(1'b0, b + 16'd2, 8'h00, "R11 slot 0 readback");
      hs_op(1'b0, base_of(3) + 16'd2, 8'h00, "R11 old window silent");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule